// File: doc/BRIEF.md
# ADC Conversion Sequencer and End Flag

This block is the digital side of a multi-channel analog-to-digital converter. Software programs one 8-bit control/status register to pick the highest channel, the mode and the interrupt enable, then sets the start bit. The block steps an external converter through channels 0 up to the chosen channel. It pulses a start strobe with a channel number and waits for a done strobe carrying a 10-bit sample. Each sample goes into one of eight read-only result registers, at the index of its channel.

In single mode one pass runs and the start bit drops by itself. In scan mode passes repeat until software clears start. Either way, the end flag rises when a pass completes. The flag, with its enable, drives an interrupt request. The flag drops only on a DMA acknowledge, or on a zero written after software has seen it set.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, every result register reads 0, and `irq` and `conv_start` are low.
- R2: Status register bits: 7 end flag, 6 interrupt enable, 5 start, 4 rate select (stored and read back, no effect on sequencing), 3 mode (0 single, 1 scan), 2..0 highest channel. A write loads bits 6..0 and they read back on `csr_rdata` the next cycle.
- R3: `res_rdata` shows, one cycle after `res_sel` is applied, the stored sample of that channel in bits 9..0 with bits 15..10 zero.
- R4: A pass issues one single-cycle `conv_start` pulse per channel, channels 0,1,... up to the highest channel in ascending order. Each `conv_done` stores `conv_result` into the result register of the channel in progress.
- R5: In single mode, the edge that takes the last channel's `conv_done` also sets the end flag and clears the start bit, and no further `conv_start` follows.
- R6: In scan mode, each completed pass sets the end flag, the start bit stays 1, and the next pass's `conv_start` for channel 0 appears in the same cycle the flag first reads 1.
- R7: Writing start to 0 in scan mode lets the channel in progress finish and store its result, after which no `conv_start` is issued.
- R8: A write with bit 7 = 0 clears the end flag only if a read strobe earlier saw the flag at 1. Without that read the flag is unchanged. A write with bit 7 = 1 never changes the flag.
- R9: A one-cycle `dma_ack` clears the end flag.
- R10: `irq` is 1 exactly when the end flag and the interrupt enable both read 1.
- R11: When a pass completes in the same cycle as an armed clearing write, the flag stays 1.
- R12: The read that arms clearing is forgotten once the flag drops: after the flag drops and is set again, a write of 0 without a new read leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Status register write strobe |
| reg_rd | input | 1 | Status register read strobe (arms flag clearing) |
| wr_data | input | 8 | Write data for the status register |
| csr_rdata | output | 8 | Current status register contents |
| res_sel | input | 3 | Result register index |
| res_rdata | output | 16 | Selected result, registered |
| conv_start | output | 1 | One-cycle request to convert `conv_ch` |
| conv_ch | output | 3 | Channel being converted |
| conv_done | input | 1 | Converter completion strobe |
| conv_result | input | 10 | Converter sample, valid with `conv_done` |
| dma_ack | input | 1 | DMA acknowledge of the end interrupt |
| irq | output | 1 | Conversion-end interrupt request |

## Verification
The hardest case to reach is the same-cycle collision of a pass completion with an armed clearing write (R11). It needs the flag already set and read, and a done strobe placed on an exact cycle. To reach it, the bench first finishes a pass and issues a read strobe. It restarts with a write that keeps bit 7 at 1, so the arm is not used up. It then holds the stand-in converter's done strobe and releases it on the same falling edge that drives the zero write. A behavioural model, compared on every clock, also covers the scan stop in mid-channel (R7).

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CSR_W      = 8;
  localparam int CH_FIELD_W = 3;
  localparam int FLAG_B     = 7;
  localparam int IE_B       = 6;
  localparam int START_B    = 5;
  localparam int RATE_B     = 4;
  localparam int SCAN_B     = 3;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_t;
endpackage

// File: rtl/adc_csr_regs.sv
module adc_csr_regs
  import adc_seq_pkg::*;
#(
  parameter int LAST_W = CH_FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [CSR_W-1:0]  wr_data,
  input  logic              round_end,
  input  logic              single_done,
  input  logic              dma_ack,
  output logic [CSR_W-1:0]  csr_rdata,
  output logic              start_o,
  output logic              scan_o,
  output logic [LAST_W-1:0] last_o,
  output logic              irq_o
);
  logic              flag_q, ie_q, start_q, rate_q, scan_q, arm_q;
  logic [LAST_W-1:0] last_q;
  logic              flag_d, ie_d, sw_clr;

  always_comb begin
    sw_clr = reg_wr && !wr_data[FLAG_B] && arm_q;
    if (round_end)
      flag_d = 1'b1;
    else if (sw_clr || dma_ack)
      flag_d = 1'b0;
    else
      flag_d = flag_q;
    ie_d = reg_wr ? wr_data[IE_B] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
      start_q <= 1'b0;
      rate_q  <= 1'b0;
      scan_q  <= 1'b0;
      arm_q   <= 1'b0;
      last_q  <= '0;
      irq_o   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
      arm_q  <= flag_d && (arm_q || (reg_rd && flag_q));
      irq_o  <= flag_d && ie_d;
      if (reg_wr) begin
        start_q <= wr_data[START_B];
        rate_q  <= wr_data[RATE_B];
        scan_q  <= wr_data[SCAN_B];
        last_q  <= wr_data[LAST_W-1:0];
      end else if (single_done) begin
        start_q <= 1'b0;
      end
    end
  end

  assign csr_rdata = {flag_q, ie_q, start_q, rate_q, scan_q, last_q};
  assign start_o   = start_q;
  assign scan_o    = scan_q;
  assign last_o    = last_q;
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_W = CH_FIELD_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            scan,
  input  logic [CH_W-1:0] last_ch,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_ch,
  output logic            res_we,
  output logic            round_end,
  output logic            single_done
);
  seq_state_t st_q;

  always_comb begin
    res_we      = (st_q == SEQ_WAIT) && conv_done;
    round_end   = res_we && (conv_ch == last_ch);
    single_done = round_end && !scan;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= SEQ_IDLE;
      conv_start <= 1'b0;
      conv_ch    <= '0;
    end else begin
      conv_start <= 1'b0;
      case (st_q)
        SEQ_IDLE: begin
          if (start) begin
            conv_start <= 1'b1;
            conv_ch    <= '0;
            st_q       <= SEQ_WAIT;
          end
        end
        default: begin
          if (conv_done) begin
            if (single_done || !start) begin
              st_q <= SEQ_IDLE;
            end else begin
              conv_start <= 1'b1;
              conv_ch    <= round_end ? '0 : conv_ch + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_result_mem.sv
module adc_result_mem #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int DATA_W = 16,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CH_W-1:0]   widx,
  input  logic [RES_W-1:0]  wdata,
  input  logic [CH_W-1:0]   rsel,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - RES_W;

  logic [RES_W-1:0] slot_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot_q[g] <= '0;
      else if (we && (widx == CH_W'(g)))
        slot_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else
      rdata <= {{PAD_W{1'b0}}, slot_q[rsel]};
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [CSR_W-1:0]      wr_data,
  output logic [CSR_W-1:0]      csr_rdata,
  input  logic [CH_FIELD_W-1:0] res_sel,
  output logic [DATA_W-1:0]     res_rdata,
  output logic                  conv_start,
  output logic [CH_FIELD_W-1:0] conv_ch,
  input  logic                  conv_done,
  input  logic [RES_W-1:0]      conv_result,
  input  logic                  dma_ack,
  output logic                  irq
);
  localparam int CH_W   = CH_FIELD_W;
  localparam int NUM_CH = 1 << CH_W;

  logic            start_w, scan_w, res_we, round_end, single_done;
  logic [CH_W-1:0] last_w;

  adc_csr_regs #(.LAST_W(CH_W)) u_csr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .wr_data(wr_data),
    .round_end(round_end), .single_done(single_done), .dma_ack(dma_ack),
    .csr_rdata(csr_rdata), .start_o(start_w), .scan_o(scan_w), .last_o(last_w),
    .irq_o(irq)
  );

  adc_chan_seq #(.CH_W(CH_W)) u_seq (
    .clk(clk), .rst(rst), .start(start_w), .scan(scan_w), .last_ch(last_w),
    .conv_done(conv_done), .conv_start(conv_start), .conv_ch(conv_ch),
    .res_we(res_we), .round_end(round_end), .single_done(single_done)
  );

  adc_result_mem #(.NUM_CH(NUM_CH), .RES_W(RES_W), .DATA_W(DATA_W), .CH_W(CH_W)) u_mem (
    .clk(clk), .rst(rst), .we(res_we), .widx(conv_ch), .wdata(conv_result),
    .rsel(res_sel), .rdata(res_rdata)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W  = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [7:0]        wr_data,
  input logic              dma_ack,
  input logic [7:0]        csr_rdata,
  input logic              irq,
  input logic              conv_start,
  input logic [2:0]        conv_ch,
  input logic [DATA_W-1:0] res_rdata,
  input logic              round_end,
  input logic              single_done
);
  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq == (csr_rdata[7] && csr_rdata[6])); // R10
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start); // R4
  AST_CH_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (conv_ch <= csr_rdata[2:0])); // R4
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    res_rdata[DATA_W-1:RES_W] == '0); // R3
  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (rst)
    (single_done && !reg_wr) |=> !csr_rdata[5]); // R5
  AST_SCAN_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (round_end && csr_rdata[3] && csr_rdata[5] && !reg_wr) |=> csr_rdata[5]); // R6
  AST_CLR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(csr_rdata[7]) |-> ($past(dma_ack) || ($past(reg_wr) && !$past(wr_data[7])))); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    round_end |=> csr_rdata[7]); // R11
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .wr_data(wr_data), .dma_ack(dma_ack),
  .csr_rdata(csr_rdata), .irq(irq), .conv_start(conv_start), .conv_ch(conv_ch),
  .res_rdata(res_rdata), .round_end(round_end), .single_done(single_done)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, dma_ack = 1'b0, conv_done = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  res_sel = '0;
  logic [9:0]  conv_result = '0;
  logic [7:0]  csr_rdata;
  logic [15:0] res_rdata;
  logic        conv_start, irq;
  logic [2:0]  conv_ch;

  int checks = 0, errors = 0, cyc = 0, cs_count = 0;
  int fire_req = 0, fire_ack = 0;
  bit hold = 0;

  always #4 clk = ~clk;

  adc_seq_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .wr_data(wr_data),
    .csr_rdata(csr_rdata), .res_sel(res_sel), .res_rdata(res_rdata),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_result(conv_result), .dma_ack(dma_ack), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // stand-in converter
  logic [9:0] exp_res [8];
  bit pend = 0; int cnt = 0, seqno = 0; logic [2:0] pch = '0;
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (rst) begin
      pend = 0;
      for (int i = 0; i < 8; i++) exp_res[i] = '0;
    end else if (conv_start) begin
      pend = 1; cnt = 3; pch = conv_ch; cs_count++;
    end else if (pend) begin
      if (!hold) cnt--;
      if ((!hold && cnt == 0) || (hold && fire_req != fire_ack)) begin
        fire_ack = fire_req;
        seqno++;
        conv_result = 10'((int'(pch) * 73 + seqno * 29 + 11) & 10'h3FF);
        exp_res[pch] = conv_result;
        conv_done = 1'b1;
        pend = 0;
      end
    end
  end

  // behavioural reference model
  bit m_flag, m_ie, m_start, m_rate, m_scan, m_arm, m_busy, m_cs;
  logic [2:0] m_last, m_ch;
  logic [9:0] m_res [8];
  logic [15:0] m_rd;
  always @(posedge clk) begin
    bit n_cs, n_busy, rend, sdone, clr, n_flag, n_arm;
    logic [2:0] n_ch;
    cyc++;
    if (rst) begin
      {m_flag, m_ie, m_start, m_rate, m_scan, m_arm, m_busy, m_cs} = '0;
      m_last = '0; m_ch = '0; m_rd = '0;
      for (int i = 0; i < 8; i++) m_res[i] = '0;
    end else begin
      n_cs = 0; n_busy = m_busy; n_ch = m_ch; rend = 0; sdone = 0;
      m_rd = {6'b0, m_res[res_sel]};
      if (!m_busy) begin
        if (m_start) begin n_cs = 1; n_ch = '0; n_busy = 1; end
      end else if (conv_done) begin
        m_res[m_ch] = conv_result;
        if (m_ch == m_last) begin
          rend = 1;
          if (!m_scan) begin n_busy = 0; sdone = 1; end
          else if (m_start) begin n_cs = 1; n_ch = '0; end
          else n_busy = 0;
        end else if (m_start) begin n_cs = 1; n_ch = m_ch + 3'd1; end
        else n_busy = 0;
      end
      clr = (reg_wr && !wr_data[7] && m_arm) || dma_ack;
      n_flag = rend ? 1'b1 : (clr ? 1'b0 : m_flag);
      n_arm = n_flag && (m_arm || (reg_rd && m_flag));
      if (reg_wr) begin
        m_ie = wr_data[6]; m_start = wr_data[5]; m_rate = wr_data[4];
        m_scan = wr_data[3]; m_last = wr_data[2:0];
      end else if (sdone) m_start = 0;
      m_flag = n_flag; m_arm = n_arm; m_cs = n_cs; m_ch = n_ch; m_busy = n_busy;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst && cyc > 2) begin
      chk("R2 csr", int'(csr_rdata), int'({m_flag, m_ie, m_start, m_rate, m_scan, m_last}));
      chk("R10 irq", int'(irq), int'(m_flag && m_ie));
      chk("R4 conv_start", int'(conv_start), int'(m_cs));
      chk("R4 conv_ch", int'(conv_ch), int'(m_ch));
      chk("R3 res_rdata", int'(res_rdata), int'(m_rd));
    end
  end

  task automatic csr_write(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; wr_data = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic csr_read();
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask
  task automatic dma_pulse();
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
  endtask
  task automatic res_read(input int i, output int v);
    @(negedge clk); res_sel = 3'(i);
    @(negedge clk); v = int'(res_rdata);
  endtask
  task automatic wait_start_low();
    for (int k = 0; k < 500 && csr_rdata[5]; k++) @(negedge clk);
  endtask

  initial begin
    int v, c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 csr reset", int'(csr_rdata), 0);
    chk("R1 irq reset", int'(irq), 0);
    chk("R1 conv_start reset", int'(conv_start), 0);
    for (int i = 0; i < 8; i++) begin res_read(i, v); chk("R1 result reset", v, 0); end

    // R2 field readback
    csr_write(8'h53);
    @(negedge clk);
    chk("R2 readback", int'(csr_rdata), 'h53);

    // R4/R5 single pass over channels 0..3
    c0 = cs_count;
    csr_write(8'h73);
    wait_start_low();
    @(negedge clk);
    chk("R5 flag set", int'(csr_rdata[7]), 1);
    chk("R5 start cleared", int'(csr_rdata[5]), 0);
    chk("R10 irq raised", int'(irq), 1);
    repeat (10) @(negedge clk);
    chk("R5 no extra start", cs_count - c0, 4);
    for (int i = 0; i < 4; i++) begin res_read(i, v); chk("R4 stored", v, int'(exp_res[i])); end
    res_read(4, v); chk("R4 beyond range untouched", v, 0);

    // R8 clearing rules
    csr_write(8'hD3);
    chk("R8 write one keeps flag", int'(csr_rdata[7]), 1);
    csr_write(8'h53);
    chk("R8 unarmed zero keeps flag", int'(csr_rdata[7]), 1);
    csr_read();
    csr_write(8'h53);
    chk("R8 armed zero clears flag", int'(csr_rdata[7]), 0);
    chk("R10 irq dropped", int'(irq), 0);

    // R9 DMA acknowledge
    csr_write(8'h71);
    wait_start_low();
    @(negedge clk);
    chk("R9 flag before ack", int'(csr_rdata[7]), 1);
    dma_pulse();
    chk("R9 ack clears", int'(csr_rdata[7]), 0);

    // R12 arm forgotten after flag drops
    csr_write(8'h70);
    wait_start_low();
    csr_read();
    dma_pulse();
    csr_write(8'h70);
    wait_start_low();
    @(negedge clk);
    csr_write(8'h50);
    chk("R12 stale arm ignored", int'(csr_rdata[7]), 1);
    csr_read();
    csr_write(8'h50);
    chk("R12 fresh arm clears", int'(csr_rdata[7]), 0);

    // R11 set and clear in the same cycle
    csr_write(8'h70);
    wait_start_low();
    csr_read();
    hold = 1;
    c0 = cs_count;
    csr_write(8'hF0);
    for (int k = 0; k < 50 && cs_count == c0; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    @(posedge clk); #1 fire_req++;
    @(negedge clk); reg_wr = 1'b1; wr_data = 8'h40;
    @(negedge clk); reg_wr = 1'b0;
    chk("R11 set wins", int'(csr_rdata[7]), 1);
    hold = 0;

    // R6 scan rounds, R7 stop
    csr_read();
    csr_write(8'h40);
    chk("R8 cleared before scan", int'(csr_rdata[7]), 0);
    csr_write(8'hEA);
    for (int k = 0; k < 500 && !csr_rdata[7]; k++) @(negedge clk);
    chk("R6 flag after round", int'(csr_rdata[7]), 1);
    chk("R6 start kept", int'(csr_rdata[5]), 1);
    chk("R6 next round starts", int'(conv_start), 1);
    chk("R6 next round at ch0", int'(conv_ch), 0);
    for (int k = 0; k < 500 && !(conv_start && conv_ch == 3'd1); k++) @(negedge clk);
    csr_write(8'hCA);
    c0 = cs_count;
    repeat (30) @(negedge clk);
    chk("R7 no start after stop", cs_count - c0, 0);
    res_read(1, v);
    chk("R7 channel in progress stored", v, int'(exp_res[1]));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule